// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software sets a source address, a destination address and a transfer count through a small register port, then arms the channel with an 8-bit control word. Each transfer request comes from a hardware strobe or from a software write. For each request the channel moves one data unit: it reads the source over a single-master bus and then writes that value to the destination.

After each unit the channel advances any address set to move forward and decrements the count. A unit that completes while the count is already zero is an underflow, and it raises a one-cycle completion pulse. In single mode an underflow disarms the channel. In repeat mode it reloads the count and any moving address from their programmed values and stays armed.

The bus port is valid/ready. The channel raises `bus_valid` with a stable address, direction, size and write data, and holds all of them until the cycle in which `bus_ready` is high. That cycle completes the beat. There is no limit on how long the bus may stall. The register port, the request strobe and the completion pulse are plain signals.

Top module: `dma_channel`

## Requirements
- R1: After reset the control word reads 0x00, `bus_valid` is low and `done_irq` is low.
- R2: Control bits 7 and 6 do not exist. Writes to them are ignored and they always read 0.
- R3: Control bit 4 (source moves forward) and bit 5 (destination moves forward) can never both be 1. A write that sets both stores bit 5 as 0.
- R4: Control bit 2 is the pending-request flag. A one-cycle `dreq` pulse sets it, and so does writing 1 to it. Writing 0 clears it, and it also clears itself in the cycle in which a transfer starts.
- R5: While control bit 3 (enable) is 0, a request is still recorded in bit 2, but no bus cycle starts.
- R6: Each request makes one read beat at the source address (`bus_write`=0) followed by one write beat at the destination address (`bus_write`=1). The write beat carries the data returned by the read. While `bus_valid` is high and `bus_ready` is low, the address and direction are held.
- R7: Control bit 0 selects the unit: 1 means byte (`bus_byte`=1) and 0 means 16-bit word. After each completed unit, a forward address advances by 1 for a byte and by 2 for a word. A fixed address does not change.
- R8: The count decrements after each completed unit. A unit that completes with the count at 0 is an underflow. It drives `done_irq` high for exactly one cycle, in the cycle after the write beat completes.
- R9: Control bit 1 selects the mode: 0 is single and 1 is repeat. On an underflow in single mode, enable clears itself, the count stays 0 and forward addresses still step.
- R10: On an underflow in repeat mode, the count and every forward address reload their last programmed values, and enable stays 1.
- R11: The register map is: offset 0 is control, 1 is source address, 2 is destination address and 3 is count. Writing offsets 1 to 3 sets both the live value and its reload value. Reads return the live value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_addr` |
| dreq | input | 1 | Hardware transfer request strobe |
| bus_valid | output | 1 | Bus beat offered |
| bus_ready | input | 1 | Bus accepts the beat this cycle |
| bus_write | output | 1 | 1 = write beat, 0 = read beat |
| bus_byte | output | 1 | 1 = byte unit, 0 = 16-bit unit |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write beat data |
| bus_rdata | input | DW | Read beat data |
| done_irq | output | 1 | One-cycle underflow pulse |

## Verification
A wrong internal state shows at the ports within a few cycles. A bad count or a bad step size puts a wrong live address or count on the register readback right after the transfer ends. It also puts a wrong address on the very next beat. A stuck request flag or enable bit shows in two ways. An extra or missing write beat appears within three cycles of the request. The control readback disagrees with the expected value at once. A wrong underflow decision moves or drops the `done_irq` pulse one cycle after the final write beat.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xfer_state_e;

  localparam int CB_UNIT = 0;
  localparam int CB_MODE = 1;
  localparam int CB_REQ  = 2;
  localparam int CB_EN   = 3;
  localparam int CB_SFWD = 4;
  localparam int CB_DFWD = 5;
  localparam int CTRL_W  = 6;

  localparam logic [1:0] RO_CTRL = 2'd0;
  localparam logic [1:0] RO_SRC  = 2'd1;
  localparam logic [1:0] RO_DST  = 2'd2;
  localparam logic [1:0] RO_CNT  = 2'd3;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_val,
  input  logic              hw_req,
  input  logic              start,
  input  logic              stop,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl;
    if (start) ctrl_d[CB_REQ] = 1'b0;
    if (stop)  ctrl_d[CB_EN]  = 1'b0;
    if (wr_en) begin
      ctrl_d = wr_val;
      if (wr_val[CB_SFWD] && wr_val[CB_DFWD]) ctrl_d[CB_DFWD] = 1'b0;
    end
    if (hw_req) ctrl_d[CB_REQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_d;
  end

  AST_ONE_DIR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[CB_SFWD] && ctrl[CB_DFWD])); // R3

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_req |=> ctrl[CB_REQ]); // R4
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wr_val,
  input  logic          step,
  input  logic          unit_byte,
  input  logic          src_fwd,
  input  logic          dst_fwd,
  input  logic          repeat_mode,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero
);
  logic [AW-1:0] src_rl, dst_rl, inc;
  logic [CW-1:0] cnt_rl;

  assign cnt_zero = (cnt == '0);
  assign inc      = unit_byte ? AW'(1) : AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0;
      src_rl <= '0; dst_rl <= '0; cnt_rl <= '0;
    end else begin
      if (step) begin
        if (cnt_zero && repeat_mode) begin
          cnt <= cnt_rl;
          if (src_fwd) src <= src_rl;
          if (dst_fwd) dst <= dst_rl;
        end else begin
          if (!cnt_zero) cnt <= cnt - CW'(1);
          if (src_fwd) src <= src + inc;
          if (dst_fwd) dst <= dst + inc;
        end
      end
      if (wr_src) begin src <= wr_val; src_rl <= wr_val; end
      if (wr_dst) begin dst <= wr_val; dst_rl <= wr_val; end
      if (wr_cnt) begin cnt <= wr_val[CW-1:0]; cnt_rl <= wr_val[CW-1:0]; end
    end
  end

  AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_zero && !wr_cnt) |=> cnt == $past(cnt) - CW'(1)); // R8

  AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !src_fwd && !wr_src) |=> $stable(src)); // R7
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enabled,
  input  logic          pending,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          start,
  output logic          complete,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          at_read,
  output logic [DW-1:0] bus_wdata
);
  xfer_state_e state, state_d;
  logic [DW-1:0] data_q;

  assign start     = (state == ST_IDLE) && enabled && pending;
  assign complete  = (state == ST_WRITE) && bus_ready;
  assign bus_valid = (state != ST_IDLE);
  assign bus_write = (state == ST_WRITE);
  assign at_read   = (state == ST_READ);
  assign bus_wdata = data_q;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (start)     state_d = ST_READ;
      ST_READ:  if (bus_ready) state_d = ST_WRITE;
      ST_WRITE: if (bus_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
    end else begin
      state <= state_d;
      if (state == ST_READ && bus_ready) data_q <= bus_rdata;
    end
  end

  AST_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bus_valid && !bus_write); // R6

  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !enabled) |=> !bus_valid); // R5

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (at_read && bus_ready) |=> bus_valid && bus_write); // R6
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          dreq,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic          bus_byte,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done_irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [AW-1:0]     src, dst;
  logic [CW-1:0]     cnt;
  logic              cnt_zero, start, complete, at_read, underflow, ctrl_we;

  assign ctrl_we   = reg_we && (reg_addr == RO_CTRL);
  assign underflow = complete && cnt_zero;
  assign bus_byte  = ctrl[CB_UNIT];

  dma_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_val(reg_wdata[CTRL_W-1:0]),
    .hw_req(dreq), .start(start), .stop(underflow && !ctrl[CB_MODE]), .ctrl(ctrl)
  );

  dma_addr_cnt #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_src(reg_we && reg_addr == RO_SRC),
    .wr_dst(reg_we && reg_addr == RO_DST),
    .wr_cnt(reg_we && reg_addr == RO_CNT),
    .wr_val(reg_wdata), .step(complete), .unit_byte(ctrl[CB_UNIT]),
    .src_fwd(ctrl[CB_SFWD]), .dst_fwd(ctrl[CB_DFWD]), .repeat_mode(ctrl[CB_MODE]),
    .src(src), .dst(dst), .cnt(cnt), .cnt_zero(cnt_zero)
  );

  dma_xfer_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enabled(ctrl[CB_EN]), .pending(ctrl[CB_REQ]),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .start(start), .complete(complete),
    .bus_valid(bus_valid), .bus_write(bus_write), .at_read(at_read), .bus_wdata(bus_wdata)
  );

  assign bus_addr = at_read ? src : dst;

  always_comb begin
    case (reg_addr)
      RO_CTRL: reg_rdata = AW'(ctrl);
      RO_SRC:  reg_rdata = src;
      RO_DST:  reg_rdata = dst;
      default: reg_rdata = AW'(cnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_irq <= 1'b0;
    else        done_irq <= underflow;
  end

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr) && $stable(bus_write)); // R6

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R8

  AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !ctrl[CB_MODE] && !$past(ctrl_we)) |-> !ctrl[CB_EN]); // R9

  AST_REPEAT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl[CB_MODE] && !ctrl_we) |=> ctrl[CB_EN]); // R10
endmodule

// File: tb/dma_channel_bench.sv
module dma_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dreq = 1'b0;
  logic        bus_valid, bus_write, bus_byte, done_irq;
  logic        stall = 1'b0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  int          n_chk = 0, n_bad = 0, n_wr = 0, n_irq = 0;
  logic [15:0] last_wd = '0;

  always #5 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  assign bus_rdata = pat(bus_addr);

  dma_channel u_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .bus_valid(bus_valid), .bus_ready(!stall), .bus_write(bus_write),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (bus_valid && !stall && bus_write) begin
      n_wr    <= n_wr + 1;
      last_wd <= bus_wdata;
    end
    if (done_irq) n_irq <= n_irq + 1;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] src, dst, cnt;
    logic [7:0]  nreq;
    logic [15:0] esrc, edst, ecnt;
    logic [7:0]  ectrl, ewr, eirq;
    logic [15:0] lsrc;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'h18, 16'h0010, 16'h0080, 16'd2, 8'd3, 16'h0016, 16'h0080, 16'd0, 8'h10, 8'd3, 8'd1, 16'h0014},
    '{8'h29, 16'h0040, 16'h0090, 16'd1, 8'd2, 16'h0040, 16'h0092, 16'd0, 8'h21, 8'd2, 8'd1, 16'h0040},
    '{8'h1A, 16'h0020, 16'h00A0, 16'd1, 8'd3, 16'h0022, 16'h00A0, 16'd0, 8'h1A, 8'd3, 8'd1, 16'h0020},
    '{8'h08, 16'h0030, 16'h00B0, 16'd3, 8'd2, 16'h0030, 16'h00B0, 16'd1, 8'h08, 8'd2, 8'd0, 16'h0030},
    '{8'h00, 16'h0070, 16'h00E0, 16'd5, 8'd1, 16'h0070, 16'h00E0, 16'd5, 8'h04, 8'd0, 8'd0, 16'h0000},
    '{8'h38, 16'h0050, 16'h00C0, 16'd0, 8'd1, 16'h0052, 16'h00C0, 16'd0, 8'h10, 8'd1, 8'd1, 16'h0050},
    '{8'hC8, 16'h0060, 16'h00D0, 16'd4, 8'd1, 16'h0060, 16'h00D0, 16'd3, 8'h08, 8'd1, 8'd0, 16'h0060}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int w0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 ctrl after reset", v, 16'h0000);
    check("R1 bus_valid after reset", {15'd0, bus_valid}, 16'd0);
    check("R1 done_irq after reset", {15'd0, done_irq}, 16'd0);

    for (int k = 0; k < 7; k++) begin
      wr(2'd0, 16'h0000);
      wr(2'd1, VEC[k].src);
      wr(2'd2, VEC[k].dst);
      wr(2'd3, VEC[k].cnt);
      wr(2'd0, {8'h00, VEC[k].ctrl});
      w0 = n_wr; i0 = n_irq;
      for (int r = 0; r < int'(VEC[k].nreq); r++) pulse_req();
      rd(2'd1, v); check($sformatf("R7 R10 R11 v%0d src", k), v, VEC[k].esrc);
      rd(2'd2, v); check($sformatf("R7 R11 v%0d dst", k), v, VEC[k].edst);
      rd(2'd3, v); check($sformatf("R8 R9 R10 v%0d count", k), v, VEC[k].ecnt);
      rd(2'd0, v); check($sformatf("R2 R3 R5 R9 R10 v%0d ctrl", k), v, {8'h00, VEC[k].ectrl});
      check($sformatf("R5 R6 v%0d write beats", k), 16'(n_wr - w0), {8'h00, VEC[k].ewr});
      check($sformatf("R8 v%0d irq pulses", k), 16'(n_irq - i0), {8'h00, VEC[k].eirq});
      if (VEC[k].ewr != 0)
        check($sformatf("R6 v%0d write data", k), last_wd, pat(VEC[k].lsrc));
    end

    // R4: a request while disabled sets the flag, and writing 0 clears it
    wr(2'd0, 16'h0000);
    pulse_req();
    rd(2'd0, v); check("R4 flag set by dreq", v, 16'h0004);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R4 flag cleared by write 0", v, 16'h0000);

    // R4: a software request starts a transfer
    wr(2'd1, 16'h0044); wr(2'd2, 16'h0088); wr(2'd3, 16'd0);
    wr(2'd0, 16'h0009);
    w0 = n_wr;
    wr(2'd0, 16'h000D);
    repeat (6) @(negedge clk);
    check("R4 software request moves one unit", 16'(n_wr - w0), 16'd1);
    rd(2'd0, v); check("R4 R9 ctrl after byte underflow", v, 16'h0001);

    // R6 back-pressure and R4 self-clear at start
    wr(2'd0, 16'h0008);
    stall = 1'b1;
    w0 = n_wr; i0 = n_irq;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    @(negedge clk);
    check("R6 read beat offered", {15'd0, bus_valid}, 16'd1);
    check("R6 read direction", {15'd0, bus_write}, 16'd0);
    check("R6 read address", bus_addr, 16'h0044);
    check("R7 word size", {15'd0, bus_byte}, 16'd0);
    rd(2'd0, v); check("R4 flag cleared at start", v, 16'h0008);
    repeat (4) @(negedge clk);
    check("R6 address held under stall", bus_addr, 16'h0044);
    check("R6 no write during stall", 16'(n_wr - w0), 16'd0);
    stall = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 write after stall", 16'(n_wr - w0), 16'd1);
    check("R6 stalled data", last_wd, pat(16'h0044));
    check("R8 irq after stalled underflow", 16'(n_irq - i0), 16'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule